// File: doc/BRIEF.md
# Arithmetic range sequence generator

This block produces signed values one at a time, in the manner of a software generator. A start pulse loads a base, a limit and a step. The block then offers the running value to a consumer. After each offered value it adds the step. It stops once the running value is no longer below the limit, and from then on it holds a completion flag high.

The consumer controls the pace through a ready input. A value is handed over only on an edge where ready and the valid flag are both high. While the consumer holds ready low, the pending value stays on the output and nothing inside the block advances. The arguments need to be present only on the start cycle. A new start may be given at any time, including in the same cycle as reset.

Top module: `arith_seq_gen`

## Requirements
- R1: An edge with `rst` high and `start` low makes `out_done` 1 and `out_valid` 0 after that edge. This holds in the middle of a sequence as well.
- R2: On a start edge, the block copies `arg_base`, `arg_limit` and `arg_step`. Later changes on those inputs do not alter the sequence in progress.
- R3: When `start` and `rst` are both high on one edge, the start takes effect and the sequence runs normally.
- R4: The emitted values are base, base+step, base+2*step and so on. Each value is emitted only while it is less than the limit under two's-complement signed comparison.
- R5: If base is greater than or equal to the limit (signed), no value is emitted and `out_done` rises.
- R6: A value transfers only on an edge with `cons_ready` and `out_valid` both high. While `out_valid` is high and `cons_ready` is low, `out_valid` stays high and `out_value` stays unchanged. No value is lost or repeated.
- R7: `out_done` is 0 after a start edge. Once the sequence is finished, `out_done` stays 1 on every cycle until the next start, whatever `cons_ready` does.
- R8: With `cons_ready` held high, the first value is valid two edges after the start edge, and later values follow every two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset to the finished state; start overrides it |
| start | input | 1 | Loads the arguments and begins a new sequence |
| cons_ready | input | 1 | Consumer can accept a value |
| arg_base | input | DATA_W | First value, signed |
| arg_limit | input | DATA_W | Exclusive upper bound, signed |
| arg_step | input | DATA_W | Increment, signed, assumed positive |
| out_valid | output | 1 | `out_value` holds a value not yet accepted |
| out_done | output | 1 | Sequence finished |
| out_value | output | DATA_W | Current value offered to the consumer |

## Verification
The embedded assertions check the following on every cycle:
- a stalled value stays in place with valid held;
- the walker does not move while held back;
- `out_done` never appears together with a pending value;
- a value is only presented while it is below the limit;
- reset forces the finished state;
- `out_done` drops after a start.

Other behaviour can only be shown by the directed scenarios:
- the actual arithmetic contents of each sequence, including negative and empty ranges;
- that the signed compare is the one in use;
- that arguments changed after start are ignored;
- the two-cycle cadence;
- that no value is dropped or repeated when ready toggles at random.

// File: rtl/arith_seq_pkg.sv
package arith_seq_pkg;
   // Walker phases: test the bound, present a value, or sit finished
   typedef enum logic [1:0] {
      SEQ_TEST = 2'd0,
      SEQ_EMIT = 2'd1,
      SEQ_FIN  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/seq_arg_regs.sv
module seq_arg_regs #(
   parameter int DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     start,
   input  logic signed [DATA_W-1:0] arg_limit,
   input  logic signed [DATA_W-1:0] arg_step,
   output logic signed [DATA_W-1:0] lim_q,
   output logic signed [DATA_W-1:0] step_q
);
   // Arguments are sampled only on the start edge (R2)
   always_ff @(posedge clk) begin
      if (start) begin
         lim_q  <= arg_limit;
         step_q <= arg_step;
      end
   end
endmodule

// File: rtl/seq_walker.sv
module seq_walker
   import arith_seq_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     start,
   input  logic                     adv,
   input  logic signed [DATA_W-1:0] arg_base,
   input  logic signed [DATA_W-1:0] lim_q,
   input  logic signed [DATA_W-1:0] step_q,
   output seq_state_e               state_q,
   output logic signed [DATA_W-1:0] cur_q,
   output logic                     emit_o,
   output logic                     fin_o
);
   logic below_lim;

   assign below_lim = (cur_q < lim_q);

   // start overrides rst (R3)
   always_ff @(posedge clk) begin
      if (start) begin
         cur_q   <= arg_base;
         state_q <= SEQ_TEST;
      end else if (rst) begin
         state_q <= SEQ_FIN;
      end else if (adv) begin
         unique case (state_q)
            SEQ_TEST: state_q <= below_lim ? SEQ_EMIT : SEQ_FIN;
            SEQ_EMIT: begin
               cur_q   <= cur_q + step_q;
               state_q <= SEQ_TEST;
            end
            default:  state_q <= SEQ_FIN;
         endcase
      end
   end

   assign emit_o = adv && !start && !rst && (state_q == SEQ_EMIT);
   assign fin_o  = !start && (rst || (adv && (state_q == SEQ_FIN)));

   // R4
   emit_below_limit_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == SEQ_EMIT) |-> (cur_q < lim_q));

   // R6
   walker_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!adv && !start) |=> ($stable(state_q) && $stable(cur_q)));
endmodule

// File: rtl/seq_out_stage.sv
module seq_out_stage #(
   parameter int DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     start,
   input  logic                     cons_ready,
   input  logic                     emit,
   input  logic                     fin,
   input  logic signed [DATA_W-1:0] cur,
   output logic                     valid_q,
   output logic                     done_q,
   output logic signed [DATA_W-1:0] value_q
);
   always_ff @(posedge clk) begin
      done_q <= 1'b0;
      if (cons_ready) valid_q <= 1'b0;
      if (emit) begin
         value_q <= cur;
         valid_q <= 1'b1;
      end
      if (fin) done_q <= 1'b1;
      if (rst && !start) valid_q <= 1'b0;
   end

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_q && !cons_ready) |=> (valid_q && $stable(value_q)));

   // R7
   done_excl_valid_chk: assert property (@(posedge clk) disable iff (rst)
      done_q |-> !valid_q);

   // R7
   done_drop_chk: assert property (@(posedge clk) disable iff (rst)
      start |=> !done_q);

   // R1
   reset_fin_chk: assert property (@(posedge clk) disable iff (start)
      rst |=> (done_q && !valid_q));
endmodule

// File: rtl/arith_seq_gen.sv
module arith_seq_gen
   import arith_seq_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     start,
   input  logic                     cons_ready,
   input  logic signed [DATA_W-1:0] arg_base,
   input  logic signed [DATA_W-1:0] arg_limit,
   input  logic signed [DATA_W-1:0] arg_step,
   output logic                     out_valid,
   output logic                     out_done,
   output logic signed [DATA_W-1:0] out_value
);
   localparam int VAL_W = DATA_W;

   if (DATA_W < 2) begin : g_bad_width
      $error("arith_seq_gen: DATA_W must be at least 2");
   end

   logic signed [VAL_W-1:0] lim_q;
   logic signed [VAL_W-1:0] step_q;
   logic signed [VAL_W-1:0] cur_q;
   seq_state_e              state_q;
   logic                    adv;
   logic                    emit;
   logic                    fin;

   // Advance only when no value is pending or the pending one leaves now (R6)
   assign adv = cons_ready || !out_valid;

   seq_arg_regs #(.DATA_W(VAL_W)) u_args (
      .clk       (clk),
      .start     (start),
      .arg_limit (arg_limit),
      .arg_step  (arg_step),
      .lim_q     (lim_q),
      .step_q    (step_q)
   );

   seq_walker #(.DATA_W(VAL_W)) u_walk (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .adv      (adv),
      .arg_base (arg_base),
      .lim_q    (lim_q),
      .step_q   (step_q),
      .state_q  (state_q),
      .cur_q    (cur_q),
      .emit_o   (emit),
      .fin_o    (fin)
   );

   seq_out_stage #(.DATA_W(VAL_W)) u_out (
      .clk        (clk),
      .rst        (rst),
      .start      (start),
      .cons_ready (cons_ready),
      .emit       (emit),
      .fin        (fin),
      .cur        (cur_q),
      .valid_q    (out_valid),
      .done_q     (out_done),
      .value_q    (out_value)
   );
endmodule

// File: tb/arith_seq_gen_tb.sv
module arith_seq_gen_tb;
   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               start = 1'b0;
   logic               cons_ready = 1'b1;
   logic signed [31:0] arg_base = '0;
   logic signed [31:0] arg_limit = '0;
   logic signed [31:0] arg_step = '0;
   logic               out_valid;
   logic               out_done;
   logic signed [31:0] out_value;

   int       n_chk = 0;
   int       n_bad = 0;
   bit [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   arith_seq_gen #(.DATA_W(32)) u_dut (
      .clk(clk), .rst(rst), .start(start), .cons_ready(cons_ready),
      .arg_base(arg_base), .arg_limit(arg_limit), .arg_step(arg_step),
      .out_valid(out_valid), .out_done(out_done), .out_value(out_value)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit next_rand();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr[0];
   endfunction

   // One sequence from start to done, checked against a model
   task automatic run_case(input string tag, input int b, input int l, input int s,
                           input bit rand_ready, input bit with_rst);
      int  exp_q[$];
      int  idx = 0;
      int  cyc = 0;
      int  last = 0;
      bit  held = 0;
      int  held_val = 0;
      for (longint v = b; v < l; v += s) exp_q.push_back(int'(v));
      @(negedge clk);
      arg_base = b; arg_limit = l; arg_step = s;
      start = 1'b1; rst = with_rst; cons_ready = 1'b1;
      @(negedge clk);
      start = 1'b0; rst = 1'b0;
      // R2: scramble arguments after the start edge
      arg_base = 32'sh1234_5678; arg_limit = 32'sh7fff_0000; arg_step = 1;
      chk(out_done == 1'b0, with_rst ? "R3" : "R7", {tag, " done after start"}, out_done, 0);
      while (!out_done && cyc < 4000) begin
         bit r;
         if (held)
            chk(out_valid && out_value == held_val, "R6", {tag, " stalled value"},
                out_value, held_val);
         r = rand_ready ? next_rand() : 1'b1;
         cons_ready = r;
         held = out_valid && !r;
         held_val = out_value;
         if (r && out_valid) begin
            if (idx < exp_q.size())
               chk(out_value == exp_q[idx], "R4", {tag, " value"}, out_value, exp_q[idx]);
            else
               chk(1'b0, "R6", {tag, " extra value"}, out_value, 0);
            if (!rand_ready)
               chk(cyc - last == 2, "R8", {tag, " cadence"}, cyc - last, 2);
            last = cyc;
            idx++;
         end
         @(negedge clk);
         cyc++;
      end
      chk(cyc < 4000, "R7", {tag, " finish"}, cyc, 0);
      chk(idx == exp_q.size(), exp_q.size() == 0 ? "R5" : "R4", {tag, " count"},
          idx, exp_q.size());
      for (int k = 0; k < 4; k++) begin
         cons_ready = k[0];
         @(negedge clk);
         chk(out_done && !out_valid, "R7", {tag, " done held"}, out_done, 1);
      end
      cons_ready = 1'b1;
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk(out_done == 1'b1, "R1", "reset done", out_done, 1);
      chk(out_valid == 1'b0, "R1", "reset valid", out_valid, 0);
      rst = 1'b0;
   endtask

   task automatic t_mid_reset();
      arg_base = 0; arg_limit = 1000; arg_step = 1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(out_done == 1'b1, "R1", "mid reset done", out_done, 1);
      chk(out_valid == 1'b0, "R1", "mid reset valid", out_valid, 0);
      repeat (3) @(negedge clk);
      chk(out_done == 1'b1, "R1", "mid reset stays done", out_done, 1);
   endtask

   initial begin
      t_reset();
      run_case("basic", 0, 10, 2, 1'b0, 1'b0);
      run_case("negative", -9, -1, 3, 1'b0, 1'b0);
      run_case("cross_zero", -2, 5, 3, 1'b0, 1'b0);
      run_case("empty_eq", 7, 7, 1, 1'b0, 1'b0);
      run_case("empty_signed", 5, -3, 1, 1'b0, 1'b0);
      run_case("start_and_rst", 1, 6, 2, 1'b0, 1'b1);
      run_case("backpressure", 3, 40, 5, 1'b1, 1'b0);
      run_case("backpressure_long", -50, 50, 7, 1'b1, 1'b0);
      t_mid_reset();
      run_case("restart", 100, 104, 1, 1'b0, 1'b0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule